// File: doc/BRIEF.md
# Indirect Read Reorder Buffer

This block puts indirect scratchpad reads back into program order. Each element of an indirect read vector claims an entry at the allocate port. The entry index goes back to the requester as a tag, and the request carries that tag out to a memory bank. The banks serve their own queues independently, so replies come back out of order. A reply is written into its entry by tag. The compute fabric then reads the returned data as a valid/ready stream, strictly in the order the entries were claimed.

Entries form a circular buffer with a head pointer and a tail pointer. Each pointer carries one extra wrap bit beyond the index. An entry is freed only at the moment the consumer accepts it from the head. Freeing and claiming may happen in the same cycle. A small occupancy state machine tracks three states:

- `OCC_EMPTY`: no entry is pending.
- `OCC_PARTIAL`: some entries are pending.
- `OCC_FULL`: all `DEPTH` entries are pending.

It moves between them on four named transitions:

- **claim-first**: `OCC_EMPTY` to `OCC_PARTIAL` on an allocation.
- **fill-up**: `OCC_PARTIAL` to `OCC_FULL` when an allocation without a release brings the count to `DEPTH`.
- **drain-last**: `OCC_PARTIAL` to `OCC_EMPTY` when a release without an allocation removes the only pending entry.
- **make-room**: `OCC_FULL` to `OCC_PARTIAL` on a release.

The state drives the allocate-ready output. `DEPTH` must be a power of two and at least 2.

Top module: `ird_reorder_buf`

## Requirements
- R1: After reset `alloc_rdy` is 1, `out_vld` is 0 and `alloc_tag` is 0.
- R2: `alloc_tag` is the tail entry index. It advances by one, modulo `DEPTH`, on every cycle with `alloc_req` and `alloc_rdy` both high, and wraps to 0 after `DEPTH-1`.
- R3: With `DEPTH` entries pending, `alloc_rdy` is 0. An `alloc_req` in that state claims nothing and does not move the tag.
- R4: The data on `out_data` is delivered in allocation order, whatever order the replies arrive in.
- R5: `out_vld` is 1 only when the head entry has received its reply. It rises in the cycle after the clock edge that captured that reply.
- R6: While `out_vld` is 1 and `out_rdy` is 0, `out_vld` and `out_data` hold their values.
- R7: An entry is freed only by a head handshake (`out_vld` and `out_rdy` both high). A handshake in the full state raises `alloc_rdy` in the next cycle.
- R8: An allocation and a head release in the same cycle both take effect. The pending count is unchanged, the tag advances, and the next entry becomes the head.
- R9: A reply is ignored if its `rsp_tag` names an entry that is not pending, or an entry that already holds its reply. A later allocation of that entry waits for a fresh reply.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| alloc_req | input | 1 | Request to claim an entry |
| alloc_rdy | output | 1 | An entry is free |
| alloc_tag | output | $clog2(DEPTH) | Index of the entry claimed by the current request |
| rsp_vld | input | 1 | Bank reply valid |
| rsp_tag | input | $clog2(DEPTH) | Entry addressed by the reply |
| rsp_data | input | DATA_W | Reply data |
| out_vld | output | 1 | Head entry holds data |
| out_rdy | input | 1 | Consumer accepts the head |
| out_data | output | DATA_W | Head entry data |

## Verification
The bench builds the buffer with `DEPTH` = 4 and `DATA_W` = 16. The small depth lets a few allocations reach the full state, and lets the tag wrap several times. It also makes it easy to test a release and an allocation in the same cycle, a stray reply to a freed entry, and a duplicate reply to a filled one.

Replies are returned in scrambled and reversed orders, and the consumer's ready signal follows a stalling pattern. The stream order is therefore checked under real reordering and backpressure.

// File: rtl/ird_pkg.sv
package ird_pkg;

    typedef enum logic [1:0] {
        OCC_EMPTY   = 2'd0,
        OCC_PARTIAL = 2'd1,
        OCC_FULL    = 2'd2
    } occ_e;

endpackage

// File: rtl/ird_ptr_ctl.sv
module ird_ptr_ctl
    import ird_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int TAG_W = $clog2(DEPTH),
    localparam int PTR_W = TAG_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             alloc_req,
    input  logic             rel_en,
    output logic             alloc_en,
    output logic             alloc_rdy,
    output logic [TAG_W-1:0] tail_idx,
    output logic [TAG_W-1:0] head_idx,
    output occ_e             occ
);

    localparam logic [PTR_W-1:0] ONE_CNT  = PTR_W'(1);
    localparam logic [PTR_W-1:0] FULL_CNT = PTR_W'(DEPTH);
    localparam logic [PTR_W-1:0] LAST_CNT = PTR_W'(DEPTH - 1);

    logic [PTR_W-1:0] head_q, tail_q, cnt;
    occ_e             state_q, state_d;

    assign cnt      = tail_q - head_q;
    assign alloc_en = alloc_req & alloc_rdy;
    assign tail_idx = tail_q[TAG_W-1:0];
    assign head_idx = head_q[TAG_W-1:0];
    assign occ      = state_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            head_q <= '0;
            tail_q <= '0;
        end else begin
            if (alloc_en) tail_q <= tail_q + ONE_CNT;
            if (rel_en)   head_q <= head_q + ONE_CNT;
        end
    end

    // Occupancy state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= OCC_EMPTY;
        else        state_q <= state_d;
    end

    // Transitions: claim-first, fill-up, drain-last, make-room
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            OCC_EMPTY: begin
                if (alloc_en) state_d = OCC_PARTIAL;
            end
            OCC_PARTIAL: begin
                if (alloc_en && !rel_en && cnt == LAST_CNT)
                    state_d = OCC_FULL;
                else if (rel_en && !alloc_en && cnt == ONE_CNT)
                    state_d = OCC_EMPTY;
            end
            OCC_FULL: begin
                if (rel_en) state_d = OCC_PARTIAL;
            end
            default: state_d = OCC_EMPTY;
        endcase
    end

    // Outputs decoded from the state
    always_comb begin
        alloc_rdy = 1'b1;
        unique case (state_q)
            OCC_FULL:    alloc_rdy = 1'b0;
            OCC_EMPTY,
            OCC_PARTIAL: alloc_rdy = 1'b1;
            default:     alloc_rdy = 1'b0;
        endcase
    end

    // R3: the state machine agrees with the pointer distance
    a_r3_full_state_tracks_count: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == FULL_CNT) |-> (state_q == OCC_FULL));

    // R1: empty pointers mean the empty state
    a_r1_empty_state_tracks_count: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == '0) |-> (state_q == OCC_EMPTY));

    // R8: a claim and a release together leave the count unchanged
    a_r8_concurrent_count_steady: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc_en && rel_en) |=> $stable(cnt));

    // R3: the count never passes the depth
    a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= FULL_CNT);

endmodule

// File: rtl/ird_slot_array.sv
module ird_slot_array #(
    parameter int DEPTH  = 16,
    parameter int DATA_W = 32,
    localparam int TAG_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              alloc_en,
    input  logic [TAG_W-1:0]  alloc_idx,
    input  logic              rel_en,
    input  logic [TAG_W-1:0]  head_idx,
    input  logic              rsp_vld,
    input  logic [TAG_W-1:0]  rsp_tag,
    input  logic [DATA_W-1:0] rsp_data,
    output logic              head_ready,
    output logic [DATA_W-1:0] head_data
);

    logic [DEPTH-1:0]  pend_q;
    logic [DEPTH-1:0]  fill_q;
    logic [DATA_W-1:0] data_q [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        logic claim, free, take;

        assign claim = alloc_en && (alloc_idx == TAG_W'(i));
        assign free  = rel_en   && (head_idx  == TAG_W'(i));
        assign take  = rsp_vld  && (rsp_tag   == TAG_W'(i)) && pend_q[i] && !fill_q[i];

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                pend_q[i] <= 1'b0;
                fill_q[i] <= 1'b0;
            end else if (claim) begin
                pend_q[i] <= 1'b1;
                fill_q[i] <= 1'b0;
            end else if (free) begin
                pend_q[i] <= 1'b0;
                fill_q[i] <= 1'b0;
            end else if (take) begin
                fill_q[i] <= 1'b1;
            end
        end

        always_ff @(posedge clk) begin
            if (take) data_q[i] <= rsp_data;
        end
    end

    assign head_ready = pend_q[head_idx] & fill_q[head_idx];
    assign head_data  = data_q[head_idx];

    // R2: an allocation never lands on a pending entry
    a_r2_alloc_hits_free_slot: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_en |-> !pend_q[alloc_idx]);

    // R7: only a pending entry can be released
    a_r7_release_pending_only: assert property (@(posedge clk) disable iff (!rst_n)
        rel_en |-> pend_q[head_idx]);

    // R9: a reply to an idle entry leaves it idle
    a_r9_stray_reply_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_vld && !pend_q[rsp_tag] && !(alloc_en && alloc_idx == rsp_tag))
            |=> !fill_q[$past(rsp_tag)]);

endmodule

// File: rtl/ird_reorder_buf.sv
module ird_reorder_buf
    import ird_pkg::*;
#(
    parameter int DEPTH  = 16,
    parameter int DATA_W = 32,
    localparam int TAG_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              alloc_req,
    output logic              alloc_rdy,
    output logic [TAG_W-1:0]  alloc_tag,
    input  logic              rsp_vld,
    input  logic [TAG_W-1:0]  rsp_tag,
    input  logic [DATA_W-1:0] rsp_data,
    output logic              out_vld,
    input  logic              out_rdy,
    output logic [DATA_W-1:0] out_data
);

    logic             alloc_en;
    logic             rel_en;
    logic [TAG_W-1:0] head_idx;
    logic             head_ready;
    occ_e             occ;

    assign out_vld = head_ready;
    assign rel_en  = head_ready & out_rdy;

    ird_ptr_ctl #(.DEPTH(DEPTH)) u_ptr (
        .clk       (clk),
        .rst_n     (rst_n),
        .alloc_req (alloc_req),
        .rel_en    (rel_en),
        .alloc_en  (alloc_en),
        .alloc_rdy (alloc_rdy),
        .tail_idx  (alloc_tag),
        .head_idx  (head_idx),
        .occ       (occ)
    );

    ird_slot_array #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_slots (
        .clk        (clk),
        .rst_n      (rst_n),
        .alloc_en   (alloc_en),
        .alloc_idx  (alloc_tag),
        .rel_en     (rel_en),
        .head_idx   (head_idx),
        .rsp_vld    (rsp_vld),
        .rsp_tag    (rsp_tag),
        .rsp_data   (rsp_data),
        .head_ready (head_ready),
        .head_data  (out_data)
    );

    // R6: a stalled output holds its value
    a_r6_hold_under_stall: assert property (@(posedge clk) disable iff (!rst_n)
        (out_vld && !out_rdy) |=> (out_vld && $stable(out_data)));

    // R5: nothing is offered while no entry is pending
    a_r5_empty_is_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (occ == OCC_EMPTY) |-> !out_vld);

    // R7: a handshake without a new claim leaves room next cycle
    a_r7_release_frees_room: assert property (@(posedge clk) disable iff (!rst_n)
        (out_vld && out_rdy && !alloc_req) |=> alloc_rdy);

    // R2: the tag steps after an accepted claim
    a_r2_tag_advances: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc_req && alloc_rdy) |=> (alloc_tag == $past(alloc_tag) + 1'b1));

endmodule

// File: tb/ird_reorder_buf_tb.sv
`timescale 1ns/1ps
module ird_reorder_buf_tb;

    localparam int DEPTH  = 4;
    localparam int DATA_W = 16;
    localparam int TAG_W  = $clog2(DEPTH);

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              alloc_req = 1'b0;
    logic              alloc_rdy;
    logic [TAG_W-1:0]  alloc_tag;
    logic              rsp_vld = 1'b0;
    logic [TAG_W-1:0]  rsp_tag = '0;
    logic [DATA_W-1:0] rsp_data = '0;
    logic              out_vld;
    logic              out_rdy;
    logic [DATA_W-1:0] out_data;

    logic              rdy_manual = 1'b0;
    logic              stress_on = 1'b0;
    logic [1:0]        rdy_cnt = '0;

    int total = 0;
    int bad   = 0;
    int pops  = 0;
    int exp_tail = 0;
    logic [DATA_W-1:0] sb_q [$];

    always #2.5 clk = ~clk;

    always @(posedge clk) rdy_cnt <= rdy_cnt + 2'd1;
    assign out_rdy = stress_on ? (rdy_cnt != 2'd3) : rdy_manual;

    ird_reorder_buf #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_dut (
        .clk, .rst_n, .alloc_req, .alloc_rdy, .alloc_tag,
        .rsp_vld, .rsp_tag, .rsp_data, .out_vld, .out_rdy, .out_data
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Scoreboard monitor: every handshake pops the next expected item (R4)
    always @(negedge clk) begin
        if (rst_n && out_vld && out_rdy) begin
            pops++;
            if (sb_q.size() == 0) check(1'b0, "R4 unexpected output", int'(out_data), 0);
            else begin
                automatic logic [DATA_W-1:0] e = sb_q.pop_front();
                check(out_data == e, "R4 order", int'(out_data), int'(e));
            end
        end
    end

    // Driver: claims an entry, records the expected item and tag (R2)
    task automatic do_alloc(input logic [DATA_W-1:0] d, output logic [TAG_W-1:0] tag);
        alloc_req = 1'b1;
        @(negedge clk);
        while (!alloc_rdy) begin
            @(posedge clk); #1;
            @(negedge clk);
        end
        tag = alloc_tag;
        check(alloc_tag == TAG_W'(exp_tail), "R2 tag", int'(alloc_tag), exp_tail);
        exp_tail = (exp_tail + 1) % DEPTH;
        sb_q.push_back(d);
        @(posedge clk); #1;
        alloc_req = 1'b0;
    endtask

    task automatic do_rsp(input logic [TAG_W-1:0] tag, input logic [DATA_W-1:0] d);
        rsp_vld = 1'b1; rsp_tag = tag; rsp_data = d;
        @(posedge clk); #1;
        rsp_vld = 1'b0;
    endtask

    task automatic wait_drain();
        int n = 0;
        while ((sb_q.size() != 0 || out_vld) && n < 500) begin
            @(posedge clk); #1; n++;
        end
        check(n < 500, "R4 drain", n, 0);
    endtask

    initial begin
        #(200000 * 5.0);
        check(1'b0, "watchdog", 0, 1);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [TAG_W-1:0] t [4];
        logic [TAG_W-1:0] tg;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R1
        check(alloc_rdy == 1'b1, "R1 alloc_rdy", int'(alloc_rdy), 1);
        check(out_vld == 1'b0, "R1 out_vld", int'(out_vld), 0);
        check(alloc_tag == '0, "R1 alloc_tag", int'(alloc_tag), 0);
        @(posedge clk); #1;

        // Fill all entries with the consumer stalled (R2, R3)
        for (int k = 0; k < 4; k++) do_alloc(16'hA000 + 16'(k), t[k]);
        @(negedge clk);
        check(alloc_rdy == 1'b0, "R3 full", int'(alloc_rdy), 0);
        @(posedge clk); #1;
        alloc_req = 1'b1;
        repeat (2) @(posedge clk);
        #1 alloc_req = 1'b0;
        @(negedge clk);
        check(alloc_tag == '0, "R3 ignored request keeps tag", int'(alloc_tag), 0);
        @(posedge clk); #1;

        // Replies out of order (R5)
        do_rsp(t[2], 16'hA002);
        @(negedge clk);
        check(out_vld == 1'b0, "R5 head missing", int'(out_vld), 0);
        @(posedge clk); #1;
        do_rsp(t[0], 16'hA000);
        @(negedge clk);
        check(out_vld == 1'b1, "R5 head filled", int'(out_vld), 1);
        check(out_data == 16'hA000, "R5 head data", int'(out_data), 16'hA000);
        @(posedge clk); #1;
        // Duplicate reply to a filled entry (R9) and stall (R6)
        do_rsp(t[0], 16'hBEEF);
        @(posedge clk); #1;
        @(negedge clk);
        check(out_vld == 1'b1 && out_data == 16'hA000, "R6/R9 held", int'(out_data), 16'hA000);
        @(posedge clk); #1;

        // One release from full (R7)
        rdy_manual = 1'b1;
        @(posedge clk); #1;
        rdy_manual = 1'b0;
        @(negedge clk);
        check(alloc_rdy == 1'b1, "R7 room after release", int'(alloc_rdy), 1);
        check(alloc_tag == '0, "R2 wrapped tag", int'(alloc_tag), 0);
        check(out_vld == 1'b0, "R5 next head empty", int'(out_vld), 0);
        @(posedge clk); #1;

        // Concurrent claim and release (R8)
        do_rsp(t[1], 16'hA001);
        do_rsp(t[3], 16'hA003);
        alloc_req = 1'b1; rdy_manual = 1'b1;
        @(negedge clk);
        check(out_vld && alloc_rdy, "R8 both enabled", int'({out_vld, alloc_rdy}), 3);
        tg = alloc_tag;
        check(tg == TAG_W'(exp_tail), "R8 tag", int'(tg), exp_tail);
        exp_tail = (exp_tail + 1) % DEPTH;
        sb_q.push_back(16'hB000);
        @(posedge clk); #1;
        alloc_req = 1'b0; rdy_manual = 1'b0;
        @(negedge clk);
        check(alloc_tag == TAG_W'(1), "R8 tag advanced", int'(alloc_tag), 1);
        check(alloc_rdy == 1'b1, "R8 count kept", int'(alloc_rdy), 1);
        check(out_vld && out_data == 16'hA002, "R8 next head", int'(out_data), 16'hA002);
        @(posedge clk); #1;
        do_alloc(16'hB001, t[1]);
        @(negedge clk);
        check(alloc_rdy == 1'b0, "R3 full after wrap", int'(alloc_rdy), 0);
        @(posedge clk); #1;

        // Drain
        rdy_manual = 1'b1;
        do_rsp(tg, 16'hB000);
        do_rsp(t[1], 16'hB001);
        wait_drain();
        rdy_manual = 1'b0;
        @(negedge clk);
        check(out_vld == 1'b0 && alloc_rdy == 1'b1, "R7 empty after drain",
              int'({out_vld, alloc_rdy}), 1);
        @(posedge clk); #1;

        // Stray reply to a free entry (R9)
        do_rsp(TAG_W'(exp_tail), 16'hDEAD);
        do_alloc(16'hC000, tg);
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            check(out_vld == 1'b0, "R9 stray reply ignored", int'(out_vld), 0);
            @(posedge clk); #1;
        end
        do_rsp(tg, 16'hC000);
        @(negedge clk);
        check(out_vld && out_data == 16'hC000, "R9 fresh reply", int'(out_data), 16'hC000);
        @(posedge clk); #1;
        rdy_manual = 1'b1;
        wait_drain();
        rdy_manual = 1'b0;

        // Reversed replies under stalling consumer (R4, R6)
        pops = 0;
        stress_on = 1'b1;
        for (int g = 0; g < 10; g++) begin
            for (int k = 0; k < 4; k++) do_alloc(16'h1000 + 16'(g * 4 + k), t[k]);
            for (int k = 3; k >= 0; k--) do_rsp(t[k], 16'h1000 + 16'(g * 4 + k));
        end
        wait_drain();
        stress_on = 1'b0;
        check(pops == 40, "R4 item count", pops, 40);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule